// File: doc/BRIEF.md
# Software-Generated Interrupt Dispatcher

This block turns a processor's store to the software-interrupt trigger word into a set-pending request for the interrupt arbiter. The request carries a 10-bit interrupt number and a per-CPU target mask, for systems of up to eight processors. Alongside the written word the block receives the index of the CPU that issued the store and the number of CPUs fitted. The arbiter uses the mask to set its per-CPU pending bits.

A 2-bit target selector in the word picks one of four ways to form the mask. The CPUs can be listed explicitly, the request can go to every CPU other than the writer, it can go back to the writer alone, or, with the reserved code, it can go to every CPU fitted. A store that does not write all four bytes is consumed and ignored. A store whose mask turns out empty is also consumed, and no request leaves the block.

Both edges use valid/ready. A write is taken on a clock edge where `wr_valid` and `wr_ready` are both high. The request is held in a single output register. `sgi_valid` rises one cycle after the write is taken and stays high, with its payload unchanged, until `sgi_ready` is seen high. While the held request is stalled, `wr_ready` is low. When the arbiter keeps `sgi_ready` high, every request is a one-cycle pulse and writes are taken back to back.

Top module: `sgi_dispatch`

## Requirements
- R1: The interrupt number on `sgi_id` equals bits 9:0 of the accepted word.
- R2: A target selector of 0 in bits 25:24 sets the mask to bits 23:16 of the word, with bit i standing for CPU i, ANDed with the fitted CPUs (CPU i is fitted when i < `num_cpus`; values above 8 count as 8).
- R3: Selector 1 targets every fitted CPU except `wr_cpu_id`.
- R4: Selector 2 targets only `wr_cpu_id`, and only if that CPU is fitted.
- R5: Selector 3, the reserved code, targets every fitted CPU.
- R6: A write with `wr_be` other than 4'b1111 is consumed without producing a request.
- R7: A write whose mask is empty (for example selector 1 with one CPU fitted) is consumed without producing a request; `sgi_valid` is never high with a zero mask.
- R8: A request becomes visible on the cycle after the write is accepted. When `sgi_ready` is high it stays for exactly one cycle.
- R9: While `sgi_valid` is high and `sgi_ready` is low, the request and its payload hold unchanged and `wr_ready` is low.
- R10: After reset `sgi_valid` is low and `wr_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | A store to the trigger word is offered |
| wr_ready | output | 1 | The block can take the store this cycle |
| wr_data | input | 32 | Written word |
| wr_be | input | 4 | Byte enables of the store |
| wr_cpu_id | input | 3 | Index of the CPU that issued the store |
| num_cpus | input | 4 | Number of CPUs fitted (1 to 8) |
| sgi_valid | output | 1 | A set-pending request is offered |
| sgi_ready | input | 1 | The arbiter takes the request |
| sgi_id | output | 10 | Interrupt number of the request |
| sgi_mask | output | 8 | Target CPUs of the request, bit i for CPU i |

## Verification
A wrong selector decode or a wrong fitted-CPU mask appears on `sgi_mask` in the cycle after the write is accepted, so a reference model compared on every clock catches it within one cycle. A broken hold register shows up as a payload that changes, or a valid that drops, while `sgi_ready` is low. It also shows up as `wr_ready` staying high during the stall, which lets a second write overwrite the first. A missing emptiness or byte-enable check produces a pulse that the model does not expect, one cycle after the offending write.

// File: rtl/sgi_pkg.sv
package sgi_pkg;
  localparam int WORD_W   = 32;
  localparam int BE_W     = WORD_W / 8;
  localparam int ID_W     = 10;
  localparam int LIST_W   = 8;
  localparam int LIST_LSB = 16;
  localparam int SEL_LSB  = 24;

  typedef enum logic [1:0] {
    TGT_LIST   = 2'd0,
    TGT_OTHERS = 2'd1,
    TGT_SELF   = 2'd2,
    TGT_ALL    = 2'd3
  } tgt_sel_e;

  typedef struct packed {
    logic [ID_W-1:0]   id;
    logic [LIST_W-1:0] list;
    tgt_sel_e          sel;
  } sgi_fields_t;
endpackage

// File: rtl/sgi_decode.sv
module sgi_decode
  import sgi_pkg::*;
(
  input  logic [WORD_W-1:0] word,
  input  logic [BE_W-1:0]   be,
  output sgi_fields_t       fields,
  output logic              full_word
);
  always_comb begin
    fields.id   = word[ID_W-1:0];
    fields.list = word[LIST_LSB +: LIST_W];
    fields.sel  = tgt_sel_e'(word[SEL_LSB +: 2]);
  end

  // R6: only a store that writes every byte lane counts
  assign full_word = &be;
endmodule

// File: rtl/sgi_target_mask.sv
module sgi_target_mask
  import sgi_pkg::*;
#(
  parameter int MAX_CPUS = 8,
  localparam int CPU_W = (MAX_CPUS > 1) ? $clog2(MAX_CPUS) : 1,
  localparam int CNT_W = $clog2(MAX_CPUS + 1)
) (
  input  tgt_sel_e            sel,
  input  logic [LIST_W-1:0]   list,
  input  logic [CPU_W-1:0]    writer,
  input  logic [CNT_W-1:0]    num_cpus,
  output logic [MAX_CPUS-1:0] mask
);
  logic [MAX_CPUS-1:0] fitted;
  logic [MAX_CPUS-1:0] writer_oh;

  for (genvar i = 0; i < MAX_CPUS; i++) begin : g_cpu
    assign fitted[i]    = (num_cpus > CNT_W'(i));
    assign writer_oh[i] = (writer == CPU_W'(i));
  end

  always_comb begin
    unique case (sel)
      TGT_LIST:   mask = list[MAX_CPUS-1:0] & fitted;
      TGT_OTHERS: mask = fitted & ~writer_oh;
      TGT_SELF:   mask = fitted & writer_oh;
      default:    mask = fitted;
    endcase
  end

  always_comb begin
    if (sel == TGT_OTHERS)
      a_r3_writer_excluded: assert ((mask & writer_oh) == '0);
    if (sel == TGT_SELF)
      a_r4_self_single: assert ($countones(mask) <= 1);
    a_r2_within_fitted: assert ((mask & ~fitted) == '0);
  end
endmodule

// File: rtl/sgi_out_reg.sv
module sgi_out_reg
  import sgi_pkg::*;
#(
  parameter int MAX_CPUS = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load,
  input  logic [ID_W-1:0]     in_id,
  input  logic [MAX_CPUS-1:0] in_mask,
  output logic                can_take,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [ID_W-1:0]     out_id,
  output logic [MAX_CPUS-1:0] out_mask
);
  assign can_take = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_id    <= '0;
      out_mask  <= '0;
    end else if (load) begin
      out_valid <= 1'b1;
      out_id    <= in_id;
      out_mask  <= in_mask;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  a_r9_hold_valid: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid);
  a_r9_hold_payload: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> $stable(out_id) && $stable(out_mask));
  a_r7_mask_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_mask != '0);
endmodule

// File: rtl/sgi_dispatch.sv
module sgi_dispatch
  import sgi_pkg::*;
#(
  parameter int MAX_CPUS = 8,
  localparam int CPU_W = (MAX_CPUS > 1) ? $clog2(MAX_CPUS) : 1,
  localparam int CNT_W = $clog2(MAX_CPUS + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_valid,
  output logic                wr_ready,
  input  logic [WORD_W-1:0]   wr_data,
  input  logic [BE_W-1:0]     wr_be,
  input  logic [CPU_W-1:0]    wr_cpu_id,
  input  logic [CNT_W-1:0]    num_cpus,
  output logic                sgi_valid,
  input  logic                sgi_ready,
  output logic [ID_W-1:0]     sgi_id,
  output logic [MAX_CPUS-1:0] sgi_mask
);
  sgi_fields_t         fields;
  logic                full_word;
  logic [MAX_CPUS-1:0] tgt_mask;
  logic                fire;
  logic                load;

  sgi_decode u_decode (
    .word      (wr_data),
    .be        (wr_be),
    .fields    (fields),
    .full_word (full_word)
  );

  sgi_target_mask #(.MAX_CPUS(MAX_CPUS)) u_mask (
    .sel      (fields.sel),
    .list     (fields.list),
    .writer   (wr_cpu_id),
    .num_cpus (num_cpus),
    .mask     (tgt_mask)
  );

  assign fire = wr_valid && wr_ready;
  assign load = fire && full_word && (tgt_mask != '0);

  sgi_out_reg #(.MAX_CPUS(MAX_CPUS)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (load),
    .in_id     (fields.id),
    .in_mask   (tgt_mask),
    .can_take  (wr_ready),
    .out_valid (sgi_valid),
    .out_ready (sgi_ready),
    .out_id    (sgi_id),
    .out_mask  (sgi_mask)
  );

  a_r8_next_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    fire && full_word && (tgt_mask != '0) |=> sgi_valid);
  a_r6_partial_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    fire && !full_word && sgi_ready |=> !sgi_valid);
  a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    sgi_valid && sgi_ready && !fire |=> !sgi_valid);
  a_r1_id_carried: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> sgi_id == $past(wr_data[ID_W-1:0]));
endmodule

// File: tb/tb_sgi_dispatch.sv
module tb_sgi_dispatch;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_valid = 1'b0;
  logic        wr_ready;
  logic [31:0] wr_data = '0;
  logic [3:0]  wr_be = 4'hF;
  logic [2:0]  wr_cpu_id = '0;
  logic [3:0]  num_cpus = 4'd4;
  logic        sgi_valid;
  logic        sgi_ready = 1'b1;
  logic [9:0]  sgi_id;
  logic [7:0]  sgi_mask;

  int checks = 0;
  int fails = 0;
  string cur_req = "R10";

  always #2 clk = ~clk;

  sgi_dispatch dut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_data(wr_data), .wr_be(wr_be), .wr_cpu_id(wr_cpu_id),
    .num_cpus(num_cpus), .sgi_valid(sgi_valid), .sgi_ready(sgi_ready),
    .sgi_id(sgi_id), .sgi_mask(sgi_mask)
  );

  // behavioural reference
  bit       m_valid = 0;
  bit [9:0] m_id = 0;
  bit [7:0] m_mask = 0;

  function automatic bit [7:0] ref_mask(bit [31:0] w, int cpu, int n);
    bit [7:0] fit = 0;
    for (int i = 0; i < 8; i++) if (i < n) fit[i] = 1'b1;
    case (w[25:24])
      2'd0: return w[23:16] & fit;
      2'd1: return fit & ~(8'd1 << cpu);
      2'd2: return fit & (8'd1 << cpu);
      default: return fit;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_valid = 0; m_id = 0; m_mask = 0;
    end else begin
      bit rdy;
      bit [7:0] mk;
      rdy = !m_valid || sgi_ready;
      mk  = ref_mask(wr_data, int'(wr_cpu_id), int'(num_cpus));
      if (wr_valid && rdy && wr_be == 4'hF && mk != 0) begin
        m_valid = 1; m_id = wr_data[9:0]; m_mask = mk;
      end else if (sgi_ready) begin
        m_valid = 0;
      end
    end
  end

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      check(sgi_valid == m_valid, cur_req, "sgi_valid", int'(sgi_valid), int'(m_valid));
      check(wr_ready == (!m_valid || sgi_ready), cur_req, "wr_ready",
            int'(wr_ready), int'(!m_valid || sgi_ready));
      if (m_valid) begin
        check(sgi_id == m_id, cur_req, "sgi_id", int'(sgi_id), int'(m_id));
        check(sgi_mask == m_mask, cur_req, "sgi_mask", int'(sgi_mask), int'(m_mask));
      end
    end
  end

  // one-cycle write offer; returns just after the edge that took (or skipped) it
  task automatic send(bit [31:0] w, bit [3:0] be, int cpu, int n);
    @(posedge clk); #1;
    wr_valid = 1; wr_data = w; wr_be = be; wr_cpu_id = 3'(cpu); num_cpus = 4'(n);
    @(posedge clk); #1;
    wr_valid = 0;
  endtask

  task automatic expect_out(bit v, int id, int mk, string req);
    check(sgi_valid == v, req, "direct valid", int'(sgi_valid), int'(v));
    if (v) begin
      check(sgi_id == 10'(id), req, "direct id", int'(sgi_id), id);
      check(sgi_mask == 8'(mk), req, "direct mask", int'(sgi_mask), mk);
    end
  endtask

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check(sgi_valid == 0, "R10", "reset valid", int'(sgi_valid), 0);
    check(wr_ready == 1, "R10", "reset ready", int'(wr_ready), 1);
    rst_n = 1;

    cur_req = "R2";
    send(32'h00A5_0123, 4'hF, 0, 4);        // list 0xA5 & 0x0F
    expect_out(1, 10'h123, 8'h05, "R2");
    cur_req = "R1";
    send(32'hFC00_03FF, 4'hF, 1, 8);        // list selector, list 0
    expect_out(0, 0, 0, "R7");
    send(32'h00FF_07FE, 4'hF, 1, 8);        // id bits above 9 ignored
    expect_out(1, 10'h3FE, 8'hFF, "R1");
    cur_req = "R3";
    send(32'h0100_0011, 4'hF, 2, 4);
    expect_out(1, 10'h011, 8'h0B, "R3");
    cur_req = "R4";
    send(32'h0200_0022, 4'hF, 5, 8);
    expect_out(1, 10'h022, 8'h20, "R4");
    send(32'h0200_0023, 4'hF, 6, 3);        // writer not fitted
    expect_out(0, 0, 0, "R4");
    cur_req = "R5";
    send(32'h0300_0033, 4'hF, 0, 6);
    expect_out(1, 10'h033, 8'h3F, "R5");
    send(32'h0300_0034, 4'hF, 0, 12);       // count above 8 clamps
    expect_out(1, 10'h034, 8'hFF, "R5");
    cur_req = "R6";
    send(32'h0300_0044, 4'h7, 0, 4);
    expect_out(0, 0, 0, "R6");
    send(32'h0300_0045, 4'h0, 0, 4);
    expect_out(0, 0, 0, "R6");
    cur_req = "R7";
    send(32'h0100_0055, 4'hF, 0, 1);
    expect_out(0, 0, 0, "R7");
    cur_req = "R8";
    send(32'h0300_0066, 4'hF, 0, 2);
    expect_out(1, 10'h066, 8'h03, "R8");
    @(posedge clk); #1;
    expect_out(0, 0, 0, "R8");

    // back-pressure
    cur_req = "R9";
    sgi_ready = 0;
    send(32'h0200_0077, 4'hF, 3, 4);
    expect_out(1, 10'h077, 8'h08, "R9");
    check(wr_ready == 0, "R9", "stalled ready", int'(wr_ready), 0);
    send(32'h0300_0088, 4'hF, 0, 4);        // offered while stalled
    expect_out(1, 10'h077, 8'h08, "R9");
    repeat (3) @(posedge clk);
    #1;
    expect_out(1, 10'h077, 8'h08, "R9");
    sgi_ready = 1;
    @(posedge clk); #1;
    expect_out(0, 0, 0, "R9");

    // back-to-back pulses
    cur_req = "R8";
    @(posedge clk); #1;
    for (int k = 0; k < 8; k++) begin
      wr_valid = 1; wr_be = 4'hF; wr_cpu_id = 3'(k); num_cpus = 4'd8;
      wr_data = {6'd0, 2'(k % 4), 8'(8'h3C + k), 6'd0, 10'(k * 37)};
      @(posedge clk); #1;
    end
    wr_valid = 0;

    // mixed pattern with intermittent stalls
    cur_req = "R2";
    for (int k = 0; k < 200; k++) begin
      @(posedge clk); #1;
      sgi_ready = (k % 5) != 1;
      wr_valid  = (k % 3) != 2;
      wr_be     = (k % 11 == 4) ? 4'hC : 4'hF;
      wr_cpu_id = 3'(k * 3);
      num_cpus  = 4'(1 + (k % 9));
      wr_data   = {6'd0, 2'(k / 7), 8'(k * 29), 6'd0, 10'(k * 113)};
    end
    @(posedge clk); #1;
    wr_valid = 0; sgi_ready = 1;
    repeat (3) @(posedge clk);
    #1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule